// File: doc/BRIEF.md
# Cache miss classifier

This block tracks the tags of a small cache and gives every access one label: hit, cold miss, capacity miss or conflict miss. Parameters set the organisation. The cache is either direct-mapped or 2-way set-associative. It holds `LINES` lines in total, and each line is one or two words. Data, write handling and any backing memory are not modelled. Only tags, fills and replacement are modelled.

Each access is a word address with a valid strobe, and one access can be accepted every clock. Two pieces of state sit beside the real tag store. The first is a bitmap of every block brought in since reset. The second is a shadow fully-associative store with LRU replacement and the same number of lines. A miss is labelled from these:

- cold, when the bitmap has never seen the block;
- conflict, when the shadow store would have hit;
- capacity, when the shadow store would also have missed.

The result leaves through registers one cycle after the access.

Top module: `miss_classifier`

## Requirements
- R1: Each cycle with `acc_valid` high yields `res_valid` high on the next cycle, with that access's result. A cycle with `acc_valid` low yields `res_valid` low on the next cycle. One access is accepted per clock.
- R2: An access that finds its block in the real cache gives `res_hit`=1 and `res_class`=2'b00. Every miss gives `res_hit`=0.
- R3: A miss is cold (`res_class`=2'b01) when its block has not been brought in since reset. The block number is the word address divided by `LINE_WORDS`. A block counts as brought in when any earlier access touched it, including a different word of the same line.
- R4: A miss is conflict (`res_class`=2'b11) when its block was brought in before and the shadow fully-associative LRU store of `LINES` entries holds the block.
- R5: A miss is capacity (`res_class`=2'b10) when its block was brought in before and the shadow store does not hold it.
- R6: A block that shares an index with a block the real cache has just evicted is not labelled conflict for that reason alone. Only the shadow store decides between conflict and capacity.
- R7: On a real miss, the block is written into the indexed set. Direct-mapped mode overwrites the single line. In 2-way mode the fill takes an empty way first, way 0 before way 1. When the set is full, it takes the least recently used way, where both hits and fills count as use.
- R8: The shadow store's contents and recency order change on every valid access, including accesses that hit in the real cache.
- R9: Synchronous active-low `rst_n` empties the real cache, the shadow store and the seen bitmap. It also drives `res_valid` low on the cycle after it is sampled.
- R10: A cycle with `acc_valid` low changes no state, whatever `acc_addr` carries.
- R11: The following sequences of word addresses must give these labels:

  | Organisation | Addresses | Labels |
  | --- | --- | --- |
  | Two one-word lines, direct-mapped | 0,1,2,3,0,1,2 | cold, cold, cold, cold, capacity, capacity, capacity |
  | Two one-word lines, direct-mapped | 0,16,0,16,0 | cold, cold, conflict, conflict, conflict |
  | Two two-word lines, direct-mapped | 0,16,17,1,18,2,18 | cold, cold, hit, conflict, cold, cold, conflict |
  | Two two-word lines, one 2-way set | 0,16,17,1,18,2,18 | cold, cold, hit, hit, cold, cold, hit |

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Word address of the access |
| res_valid | output | 1 | Result of the previous cycle's access is present |
| res_hit | output | 1 | Access hit in the real cache |
| res_class | output | 2 | 00 hit, 01 cold, 10 capacity, 11 conflict |

## Verification
The hardest label to reach from the ports is one that depends on recency the shadow store gained through a real-cache hit. A short sequence tests this. It re-touches a block, so that the real cache hits, and then forces an eviction. If the shadow store had not updated on that hit, the next miss would be labelled conflict where it should be capacity. A second short sequence drives 2-way LRU victim choice in the same way.

Three instances (one-word direct-mapped, two-word direct-mapped, two-word 2-way) receive the same stimulus, and each is checked against a timestamp-based reference model. Random addresses are drawn mostly from a narrow window. This keeps blocks returning within the cache's capacity, so all three miss classes occur often.

// File: rtl/miss_classifier.sv
module miss_classifier #(
  parameter int ADDR_W      = 16,
  parameter int WAYS        = 1,
  parameter int LINE_WORDS  = 1,
  parameter int LINES       = 2,
  parameter int SEEN_BLOCKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [1:0]        res_class
);

  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int SETS   = LINES / WAYS;
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LN_W   = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int SEEN_W = $clog2(SEEN_BLOCKS);

  localparam logic [1:0] CL_HIT  = 2'b00;
  localparam logic [1:0] CL_COLD = 2'b01;
  localparam logic [1:0] CL_CAP  = 2'b10;
  localparam logic [1:0] CL_CONF = 2'b11;

  logic [BLK_W-1:0] blk;
  logic [IDX_W-1:0] idx;
  logic [LN_W-1:0]  base;
  logic             unused_low;

  assign blk = acc_addr[ADDR_W-1:OFF_W];

  generate
    if (OFF_W > 0) begin : g_off
      assign unused_low = ^acc_addr[OFF_W-1:0];
    end else begin : g_nooff
      assign unused_low = 1'b0;
    end
    if (SETS > 1) begin : g_idx
      assign idx = blk[IDX_W-1:0];
    end else begin : g_noidx
      assign idx = '0;
    end
  endgenerate

  assign base = LN_W'(int'(idx) * WAYS);

  logic [LINES-1:0] r_valid;
  logic [BLK_W-1:0] r_tag [LINES];
  logic             real_hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] used_way;
  logic [LN_W-1:0]  fill_line;

  always_comb begin
    real_hit = 1'b0;
    hit_way  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (r_valid[int'(base) + w] && r_tag[int'(base) + w] == blk) begin
        real_hit = 1'b1;
        hit_way  = WAY_W'(w);
      end
    end
  end

  generate
    if (WAYS == 2) begin : g_two
      logic [SETS-1:0] lru;
      always_ff @(posedge clk) begin
        if (!rst_n)         lru <= '0;
        else if (acc_valid) lru[idx] <= ~used_way;
      end
      assign victim = !r_valid[base]         ? 1'b0 :
                      !r_valid[base + 1'b1]  ? 1'b1 : lru[idx];
    end else begin : g_one
      assign victim = '0;
    end
  endgenerate

  assign used_way  = real_hit ? hit_way : victim;
  assign fill_line = base + LN_W'(used_way);

  always_ff @(posedge clk) begin
    if (!rst_n)                     r_valid <= '0;
    else if (acc_valid && !real_hit) r_valid[fill_line] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (acc_valid && !real_hit) r_tag[fill_line] <= blk;
  end

  logic [LINES-1:0] s_valid;
  logic [BLK_W-1:0] s_tag [LINES];
  logic             shadow_hit;
  logic [LN_W-1:0]  s_pos;

  always_comb begin
    shadow_hit = 1'b0;
    s_pos      = '0;
    for (int k = 0; k < LINES; k++) begin
      if (s_valid[k] && s_tag[k] == blk) begin
        shadow_hit = 1'b1;
        s_pos      = LN_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= '0;
    end else if (acc_valid) begin
      s_valid[0] <= 1'b1;
      for (int k = 1; k < LINES; k++)
        if (!shadow_hit || k <= int'(s_pos)) s_valid[k] <= s_valid[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (acc_valid) begin
      s_tag[0] <= blk;
      for (int k = 1; k < LINES; k++)
        if (!shadow_hit || k <= int'(s_pos)) s_tag[k] <= s_tag[k-1];
    end
  end

  logic [SEEN_BLOCKS-1:0] seen_map;
  logic                   seen_hit;

  assign seen_hit = seen_map[blk[SEEN_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)         seen_map <= '0;
    else if (acc_valid) seen_map[blk[SEEN_W-1:0]] <= 1'b1;
  end

  logic [1:0] cls_next;

  assign cls_next = real_hit   ? CL_HIT  :
                    !seen_hit  ? CL_COLD :
                    shadow_hit ? CL_CONF : CL_CAP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_class <= CL_HIT;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_hit   <= real_hit;
        res_class <= cls_next;
      end
    end
  end

endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
  parameter int SEEN_BLOCKS = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic                   res_valid,
  input logic                   res_hit,
  input logic [1:0]             res_class,
  input logic                   real_hit,
  input logic                   seen_hit,
  input logic                   shadow_hit,
  input logic [SEEN_BLOCKS-1:0] seen_map
);

  p_res_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  p_res_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  p_hit_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_class == 2'b00)));

  p_cold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !seen_hit |=> res_valid && res_class == 2'b01);

  p_conflict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !real_hit && seen_hit && shadow_hit |=> res_class == 2'b11);

  p_capacity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !real_hit && seen_hit && !shadow_hit |=> res_class == 2'b10);

  p_seen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(seen_map));

  logic rst_q;
  always_ff @(posedge clk) rst_q <= !rst_n;

  always @(negedge clk) begin
    if (rst_q) begin
      p_reset_clear_r9: assert (!res_valid && seen_map == '0);
    end
  end

endmodule

bind miss_classifier miss_classifier_chk #(.SEEN_BLOCKS(SEEN_BLOCKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .res_valid  (res_valid),
  .res_hit    (res_hit),
  .res_class  (res_class),
  .real_hit   (real_hit),
  .seen_hit   (seen_hit),
  .shadow_hit (shadow_hit),
  .seen_map   (seen_map)
);

// File: tb/test_miss_classifier.sv
`timescale 1ns/1ps
module test_miss_classifier;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        rv [3];
  logic        rh [3];
  logic [1:0]  rc [3];
  int          n_tests = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  miss_classifier #(.WAYS(1), .LINE_WORDS(1)) i_miss_classifier (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(rv[0]), .res_hit(rh[0]), .res_class(rc[0]));

  miss_classifier #(.WAYS(1), .LINE_WORDS(2)) i_miss_classifier_dm2 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(rv[1]), .res_hit(rh[1]), .res_class(rc[1]));

  miss_classifier #(.WAYS(2), .LINE_WORDS(2)) i_miss_classifier_sa2 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(rv[2]), .res_hit(rh[2]), .res_class(rc[2]));

  // reference model: timestamps per entry
  int m_rtag [3][2];
  bit m_rval [3][2];
  int m_rtime[3][2];
  int m_stag [3][2];
  bit m_sval [3][2];
  int m_stime[3][2];
  bit m_seen [3][64];
  int tnow;

  task automatic model_clear();
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 2; k++) begin
        m_rval[c][k] = 0; m_sval[c][k] = 0;
        m_rtime[c][k] = 0; m_stime[c][k] = 0;
      end
      for (int b = 0; b < 64; b++) m_seen[c][b] = 0;
    end
  endtask

  task automatic model_access(input int c, input int a, output bit hit, output logic [1:0] cls);
    int lw, ways, blk, sets, base, vic;
    bit shit;
    lw = (c == 0) ? 1 : 2;
    ways = (c == 2) ? 2 : 1;
    blk = a / lw;
    sets = 2 / ways;
    base = (blk % sets) * ways;
    tnow++;
    hit = 0;
    for (int w = 0; w < ways; w++)
      if (m_rval[c][base+w] && m_rtag[c][base+w] == blk) begin
        hit = 1; m_rtime[c][base+w] = tnow;
      end
    shit = 0;
    for (int k = 0; k < 2; k++)
      if (m_sval[c][k] && m_stag[c][k] == blk) begin
        shit = 1; m_stime[c][k] = tnow;
      end
    if (hit)                cls = 2'b00;
    else if (!m_seen[c][blk]) cls = 2'b01;
    else if (shit)          cls = 2'b11;
    else                    cls = 2'b10;
    if (!hit) begin
      vic = -1;
      for (int w = 0; w < ways; w++)
        if (vic < 0 && !m_rval[c][base+w]) vic = base + w;
      if (vic < 0) begin
        vic = base;
        for (int w = 1; w < ways; w++)
          if (m_rtime[c][base+w] < m_rtime[c][vic]) vic = base + w;
      end
      m_rval[c][vic] = 1; m_rtag[c][vic] = blk; m_rtime[c][vic] = tnow;
    end
    if (!shit) begin
      vic = -1;
      for (int k = 0; k < 2; k++)
        if (vic < 0 && !m_sval[c][k]) vic = k;
      if (vic < 0) vic = (m_stime[c][1] < m_stime[c][0]) ? 1 : 0;
      m_sval[c][vic] = 1; m_stag[c][vic] = blk; m_stime[c][vic] = tnow;
    end
    m_seen[c][blk] = 1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input bit v, input logic [1:0] cls);
    if (!v) return "R1 idle";
    case (cls)
      2'b00:   return "R2 hit";
      2'b01:   return "R3 cold";
      2'b10:   return "R5 capacity";
      default: return "R4 conflict";
    endcase
  endfunction

  task automatic do_reset();
    acc_valid = 1'b0;
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < 3; c++)
      check(rv[c] == 1'b0, "R9 reset res_valid", int'(rv[c]), 0);
    rst_n = 1'b1;
  endtask

  task automatic acc(input bit v, input int a);
    bit         eh [3];
    logic [1:0] ec [3];
    int         act, exp;
    acc_valid = v;
    acc_addr  = 16'(a);
    for (int c = 0; c < 3; c++) begin
      eh[c] = 0; ec[c] = 2'b00;
      if (v) model_access(c, a, eh[c], ec[c]);
    end
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      exp = v ? (4 + (int'(eh[c]) << 2) * 0 + int'(eh[c]) * 8 + int'(ec[c])) : 0;
      act = rv[c] ? (4 + int'(rh[c]) * 8 + int'(rc[c])) : 0;
      check(act == exp, req_of(v, ec[c]), act, exp);
    end
  endtask

  task automatic expect_cls(input int c, input logic [1:0] code, input string req);
    check(rv[c] && rc[c] == code, req, int'(rc[c]), int'(code));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tnow = 0;
    void'($urandom(32'd20250117));
    do_reset();

    // R11 R5 R6: 0,1,2,3,0,1,2 on one-word direct-mapped
    acc(1, 0); expect_cls(0, 2'b01, "R11 seq1 a0");
    acc(1, 1); expect_cls(0, 2'b01, "R11 seq1 a1");
    acc(1, 2); expect_cls(0, 2'b01, "R11 seq1 a2");
    acc(1, 3); expect_cls(0, 2'b01, "R11 seq1 a3");
    acc(1, 0); expect_cls(0, 2'b10, "R6 shared index gives capacity");
    acc(1, 1); expect_cls(0, 2'b10, "R11 seq1 a1 again");
    acc(1, 2); expect_cls(0, 2'b10, "R11 seq1 a2 again");

    // R11 R4: 0,16,0,16,0
    do_reset();
    acc(1, 0);  expect_cls(0, 2'b01, "R11 seq2 a0");
    acc(1, 16); expect_cls(0, 2'b01, "R11 seq2 a16");
    acc(1, 0);  expect_cls(0, 2'b11, "R4 thrash 0");
    acc(1, 16); expect_cls(0, 2'b11, "R4 thrash 16");
    acc(1, 0);  expect_cls(0, 2'b11, "R4 thrash 0 again");

    // R11 R3 R7: 0,16,17,1,18,2,18 on both two-word organisations
    do_reset();
    acc(1, 0);  expect_cls(1, 2'b01, "R11 dm2 a0");  expect_cls(2, 2'b01, "R11 sa2 a0");
    acc(1, 16); expect_cls(1, 2'b01, "R11 dm2 a16"); expect_cls(2, 2'b01, "R11 sa2 a16");
    acc(1, 17); expect_cls(1, 2'b00, "R3 neighbour word hit dm2"); expect_cls(2, 2'b00, "R3 neighbour word hit sa2");
    acc(1, 1);  expect_cls(1, 2'b11, "R4 dm2 a1");   expect_cls(2, 2'b00, "R7 sa2 a1 hit");
    acc(1, 18); expect_cls(1, 2'b01, "R11 dm2 a18"); expect_cls(2, 2'b01, "R11 sa2 a18");
    acc(1, 2);  expect_cls(1, 2'b01, "R11 dm2 a2");  expect_cls(2, 2'b01, "R11 sa2 a2");
    acc(1, 18); expect_cls(1, 2'b11, "R4 dm2 a18");  expect_cls(2, 2'b00, "R7 sa2 a18 hit");

    // R7: 2-way LRU victim follows hits
    do_reset();
    acc(1, 0); acc(1, 16); acc(1, 0);
    acc(1, 18); expect_cls(2, 2'b01, "R7 sa2 fill evicts block 8");
    acc(1, 16); expect_cls(2, 2'b10, "R7 sa2 evicted way misses");

    // R8: shadow recency moves on a real hit
    do_reset();
    acc(1, 1); acc(1, 0);
    acc(1, 1); expect_cls(0, 2'b00, "R8 real hit");
    acc(1, 2); expect_cls(0, 2'b01, "R8 cold fill");
    acc(1, 0); expect_cls(0, 2'b10, "R8 shadow recency from hit");

    // R10 R1: idle cycle with an address leaves state alone
    do_reset();
    acc(1, 0);
    acc(0, 2);
    for (int c = 0; c < 3; c++) check(rv[c] == 1'b0, "R1 idle gives no result", int'(rv[c]), 0);
    acc(1, 0);
    for (int c = 0; c < 3; c++) expect_cls(c, 2'b00, "R10 idle did not fill");

    // R9: reset forgets history
    do_reset();
    acc(1, 0);
    for (int c = 0; c < 3; c++) expect_cls(c, 2'b01, "R9 cold after reset");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v;
      int a;
      v = ($urandom % 8) != 0;
      a = ($urandom % 2 == 0) ? int'($urandom % 8) : int'($urandom % 64);
      acc(v, a);
      if (i == 2000) do_reset();
    end

    acc_valid = 1'b0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule